// File: doc/BRIEF.md
# Dual-Mode Interrupt Priority Router

The router gathers level-sensitive requests from four on-board sources (two peripheral-interface controllers, an Ethernet controller and a serial controller whose two channel requests arrive already ORed) plus an internally generated non-maskable request. It turns them into a processor interrupt priority level and an autovector number. Each source owns one bit of an 8-bit pending register. The bit a source owns comes from one of two routing tables, picked by a mode input. In the classic table the Ethernet request does not reach the processor. It is diverted to a separate expansion-slot interrupt line.

The output comes from the highest pending bit. A one-shot pulse generator turns a trigger edge into a non-maskable request that lasts a parameterised number of clock cycles and then drops by itself. The mode input is registered. A mode change only affects source transitions seen after it has been registered, so bits already pending stay where they are.

Top module: `irq_prio_router`

## Requirements
- R1: After reset the pending register, `ipl_o`, `vec_o` and `slot_irq_o` are all 0. The registered mode is alternate (0), even when `mode_i` is held at 1 during reset.
- R2: With mode 1 (classic), source 0 maps to pending bit 0, source 1 to bit 1 and source 3 to bit 3. `src_i` bit k is source k.
- R3: With mode 1, a change on source 2 (Ethernet) leaves the pending register untouched and is copied to `slot_irq_o` one clock later.
- R4: With mode 0 (alternate), source 0 maps to bit 5, source 1 to bit 1, source 2 to bit 2 and source 3 to bit 3. `slot_irq_o` stays 0.
- R5: A routed pending bit is set on the clock edge that sees its source rise. It is cleared on the edge that sees the source fall.
- R6: If the highest set pending bit is i, then `ipl_o` = i+1 and `vec_o` = i+25. With no bit set, both are 0.
- R7: `ipl_o` and `vec_o` are registered and follow the pending register one clock later.
- R8: A rising edge on `nmi_trig_i` starts a non-maskable request. The request maps to bit 6 in both modes and lasts HOLD_CYC cycles, then releases without further input.
- R9: A new trigger edge during a hold reloads the hold count to its full value.
- R10: A mode change moves no pending bit. A source edge seen on the same clock edge that registers a new mode is routed by the previous mode.
- R11: Pending bit 7 is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Routing table select: 1 classic, 0 alternate |
| src_i | input | 4 | Source requests: bit0 VIA-A, bit1 VIA-B, bit2 Ethernet, bit3 serial |
| nmi_trig_i | input | 1 | Non-maskable pulse trigger, rising edge |
| ipl_o | output | 3 | Processor interrupt priority level |
| vec_o | output | 8 | Autovector number |
| slot_irq_o | output | 1 | Expansion-slot interrupt, carries Ethernet in classic mode |
| pend_o | output | 8 | Pending register |

## Verification
Two functions can act on the same clock edge: registering a new mode and routing a source edge. The bench changes `mode_i` and a source input in the same cycle, then checks that the source lands at the bit position of the mode that was in force before. A second collision comes from a trigger edge that arrives in the middle of a non-maskable hold. The bench times the release and checks that the hold now ends a full HOLD_CYC cycles after the second trigger, and not after the first.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NUM_SRC  = 5;
  localparam int PEND_W   = 8;
  localparam int POS_W    = $clog2(PEND_W);
  localparam int LVL_W    = 3;
  localparam int VEC_W    = 8;
  localparam int VEC_BASE = 25;

  localparam int SRC_VIA_A = 0;
  localparam int SRC_VIA_B = 1;
  localparam int SRC_ETH   = 2;
  localparam int SRC_SER   = 3;
  localparam int SRC_NMI   = 4;

  typedef struct packed {
    logic             hit;
    logic [POS_W-1:0] pos;
  } route_t;

  // hit=0 means the source goes to the slot line instead of pending
  function automatic route_t route_lookup(input int idx, input logic classic);
    route_t r;
    r.hit = 1'b1;
    r.pos = '0;
    case (idx)
      SRC_VIA_A: r.pos = classic ? POS_W'(0) : POS_W'(5);
      SRC_VIA_B: r.pos = POS_W'(1);
      SRC_ETH:   begin r.hit = !classic; r.pos = POS_W'(2); end
      SRC_SER:   r.pos = POS_W'(3);
      SRC_NMI:   r.pos = POS_W'(6);
      default:   r.hit = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/irq_pend_track.sv
module irq_pend_track
  import irq_router_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               classic_i,
  input  logic [NUM_SRC-1:0] lvl_i,
  output logic [PEND_W-1:0]  pend_o,
  output logic               slot_o
);
  logic [NUM_SRC-1:0] lvl_q;
  logic [PEND_W-1:0]  pend_q, pend_d;
  logic               slot_q, slot_d;
  route_t             rt;

  always_comb begin
    pend_d = pend_q;
    slot_d = slot_q;
    rt     = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      rt = route_lookup(k, classic_i);
      if (lvl_i[k] != lvl_q[k]) begin
        if (rt.hit) pend_d[rt.pos] = lvl_i[k];
        else        slot_d         = lvl_i[k];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      pend_q <= '0;
      slot_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_i;
      pend_q <= pend_d;
      slot_q <= slot_d;
    end
  end

  assign pend_o = pend_q;
  assign slot_o = slot_q;
endmodule

// File: rtl/irq_nmi_pulse.sv
module irq_nmi_pulse #(
  parameter int HOLD_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic nmi_o
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);

  logic             trig_q;
  logic [CNT_W-1:0] cnt_q;
  logic             load;

  assign load = trig_i & ~trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      trig_q <= trig_i;
      if (load)              cnt_q <= CNT_W'(HOLD_CYC);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  assign nmi_o = (cnt_q != '0);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_router_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PEND_W-1:0] pend_i,
  output logic [LVL_W-1:0]  ipl_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [LVL_W-1:0] ipl_d, ipl_q;
  logic [VEC_W-1:0] vec_d, vec_q;

  // ascending scan: the last hit is the highest bit
  always_comb begin
    ipl_d = '0;
    vec_d = '0;
    for (int i = 0; i < PEND_W; i++) begin
      if (pend_i[i]) begin
        ipl_d = LVL_W'(i + 1);
        vec_d = VEC_W'(i + VEC_BASE);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ipl_q <= '0;
      vec_q <= '0;
    end else begin
      ipl_q <= ipl_d;
      vec_q <= vec_d;
    end
  end

  assign ipl_o = ipl_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/irq_prio_router.sv
module irq_prio_router
  import irq_router_pkg::*;
#(
  parameter int HOLD_CYC = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mode_i,
  input  logic [NUM_SRC-2:0]   src_i,
  input  logic                 nmi_trig_i,
  output logic [LVL_W-1:0]     ipl_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic                 slot_irq_o,
  output logic [PEND_W-1:0]    pend_o
);
  logic mode_q;
  logic nmi_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= mode_i;
  end

  irq_nmi_pulse #(.HOLD_CYC(HOLD_CYC)) u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (nmi_trig_i),
    .nmi_o  (nmi_lvl)
  );

  irq_pend_track u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .classic_i (mode_q),
    .lvl_i     ({nmi_lvl, src_i}),
    .pend_o    (pend_o),
    .slot_o    (slot_irq_o)
  );

  irq_prio_enc u_enc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend_o),
    .ipl_o  (ipl_o),
    .vec_o  (vec_o)
  );
endmodule

// File: rtl/irq_prio_router_chk.sv
module irq_prio_router_chk
  import irq_router_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               mode_q,
  input logic [NUM_SRC-2:0] src_i,
  input logic               nmi_trig_i,
  input logic [LVL_W-1:0]   ipl_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic [PEND_W-1:0]  pend_o
);
  a_r11_top_bit_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_o[7]);

  a_r6_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o == '0) |=> (ipl_o == '0 && vec_o == '0));

  a_r7_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(pend_o) |=> ($stable(ipl_o) && $stable(vec_o)));

  a_r5_via_b_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_i[1] |=> pend_o[1]);

  a_r5_via_b_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_i[1] |=> !pend_o[1]);

  a_r3_eth_no_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && (src_i[2] != $past(src_i[2]))) |=> $stable(pend_o[2]));

  a_r8_nmi_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_trig_i) |=> ##1 pend_o[6]);
endmodule

bind irq_prio_router irq_prio_router_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_q     (mode_q),
  .src_i      (src_i),
  .nmi_trig_i (nmi_trig_i),
  .ipl_o      (ipl_o),
  .vec_o      (vec_o),
  .pend_o     (pend_o)
);

// File: tb/tb_irq_prio_router.sv
`timescale 1ns/1ps
module tb_irq_prio_router;
  localparam int HOLD = 20;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_i = 1'b0;
  logic [3:0] src_i = '0;
  logic       nmi_trig_i = 1'b0;
  logic [2:0] ipl_o;
  logic [7:0] vec_o;
  logic       slot_irq_o;
  logic [7:0] pend_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  irq_prio_router #(.HOLD_CYC(HOLD)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .src_i      (src_i),
    .nmi_trig_i (nmi_trig_i),
    .ipl_o      (ipl_o),
    .vec_o      (vec_o),
    .slot_irq_o (slot_irq_o),
    .pend_o     (pend_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic out_chk(input string req, input logic [7:0] p, input logic [2:0] l, input logic [7:0] v);
    chk({req, " pend"}, 32'(pend_o), 32'(p));
    chk({req, " ipl"}, 32'(ipl_o), 32'(l));
    chk({req, " vec"}, 32'(vec_o), 32'(v));
  endtask

  task automatic do_reset(input logic m);
    rst_ni = 1'b0; src_i = '0; nmi_trig_i = 1'b0; mode_i = m;
    tick(2);
    rst_ni = 1'b1;
    tick(2);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0; src_i = '0; nmi_trig_i = 1'b0; mode_i = 1'b1;
    tick(2);
    out_chk("R1 reset", 8'h00, 3'd0, 8'd0);
    chk("R1 reset slot", 32'(slot_irq_o), 0);
    rst_ni = 1'b1;
    src_i[0] = 1'b1;  // routed by reset mode (alternate) -> bit 5
    tick(2);
    out_chk("R1 mode after reset", 8'h20, 3'd6, 8'd30);
  endtask

  task automatic t_alt_map;
    do_reset(1'b0);
    src_i[0] = 1'b1; tick(2); out_chk("R4 via_a", 8'h20, 3'd6, 8'd30);
    src_i[1] = 1'b1; tick(2); out_chk("R4 via_b", 8'h22, 3'd6, 8'd30);
    src_i[2] = 1'b1; tick(2); out_chk("R4 eth", 8'h26, 3'd6, 8'd30);
    chk("R4 slot idle", 32'(slot_irq_o), 0);
    src_i[3] = 1'b1; tick(2); out_chk("R4 ser", 8'h2E, 3'd6, 8'd30);
    src_i[0] = 1'b0; tick(2); out_chk("R5 R6 drop via_a", 8'h0E, 3'd4, 8'd28);
    src_i[3] = 1'b0; tick(2); out_chk("R5 R6 drop ser", 8'h06, 3'd3, 8'd27);
    src_i[2] = 1'b0; tick(2); out_chk("R5 R6 drop eth", 8'h02, 3'd2, 8'd26);
    src_i[1] = 1'b0; tick(2); out_chk("R6 none", 8'h00, 3'd0, 8'd0);
  endtask

  task automatic t_classic_map;
    do_reset(1'b1);
    src_i[0] = 1'b1; tick(2); out_chk("R2 via_a", 8'h01, 3'd1, 8'd25);
    src_i[1] = 1'b1; tick(2); out_chk("R2 via_b", 8'h03, 3'd2, 8'd26);
    src_i[3] = 1'b1; tick(2); out_chk("R2 ser", 8'h0B, 3'd4, 8'd28);
  endtask

  task automatic t_classic_eth;
    do_reset(1'b1);
    src_i[2] = 1'b1; tick(1);
    chk("R3 slot set", 32'(slot_irq_o), 1);
    tick(1); out_chk("R3 no pend", 8'h00, 3'd0, 8'd0);
    src_i[2] = 1'b0; tick(1);
    chk("R3 slot clr", 32'(slot_irq_o), 0);
  endtask

  task automatic t_latency;
    do_reset(1'b0);
    src_i[1] = 1'b1; tick(1);
    chk("R7 pend first", 32'(pend_o), 32'h02);
    chk("R7 ipl lags", 32'(ipl_o), 0);
    tick(1);
    chk("R7 ipl follows", 32'(ipl_o), 2);
  endtask

  task automatic t_mode_keep;
    do_reset(1'b1);
    src_i[0] = 1'b1; tick(2); out_chk("R10 classic set", 8'h01, 3'd1, 8'd25);
    mode_i = 1'b0; tick(2); out_chk("R10 no move", 8'h01, 3'd1, 8'd25);
    src_i[0] = 1'b0; tick(2); out_chk("R10 stale bit", 8'h01, 3'd1, 8'd25);
    src_i[0] = 1'b1; tick(2); out_chk("R10 new pos", 8'h21, 3'd6, 8'd30);
  endtask

  task automatic t_same_cycle;
    do_reset(1'b0);
    mode_i = 1'b1; src_i[0] = 1'b1;
    tick(2); out_chk("R10 same edge old mode", 8'h20, 3'd6, 8'd30);
  endtask

  task automatic t_nmi;
    do_reset(1'b0);
    nmi_trig_i = 1'b1; tick(1);
    nmi_trig_i = 1'b0; tick(2);
    out_chk("R8 nmi on", 8'h40, 3'd7, 8'd31);
    tick(18); chk("R8 still held", 32'(pend_o[6]), 1);
    tick(1);  chk("R8 released", 32'(pend_o[6]), 0);
    tick(1);  out_chk("R8 outputs idle", 8'h00, 3'd0, 8'd0);
  endtask

  task automatic t_nmi_retrig;
    do_reset(1'b0);
    nmi_trig_i = 1'b1; tick(1);
    nmi_trig_i = 1'b0; tick(9);
    nmi_trig_i = 1'b1; tick(1);
    nmi_trig_i = 1'b0; tick(19);
    chk("R9 hold extended", 32'(pend_o[6]), 1);
    tick(2);
    chk("R9 released late", 32'(pend_o[6]), 0);
  endtask

  task automatic t_all;
    do_reset(1'b0);
    src_i = 4'hF; nmi_trig_i = 1'b1; tick(1);
    nmi_trig_i = 1'b0; tick(2);
    out_chk("R6 R11 all active", 8'h6E, 3'd7, 8'd31);
    chk("R11 bit7", 32'(pend_o[7]), 0);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_alt_map();
    t_classic_map();
    t_classic_eth();
    t_latency();
    t_mode_keep();
    t_same_cycle();
    t_nmi();
    t_nmi_retrig();
    t_all();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule